// File: doc/BRIEF.md
# Private Interrupt Pending-Set Front End

This block sits in front of the pending latches of one processor's 32 private interrupts. It turns two kinds of event into single-cycle pending-set pulses. The first kind is a change on the 16 peripheral lines that carry interrupt IDs 16 to 31. The second kind is a software-generated interrupt request for IDs 0 to 15. Whenever something happens that could change the winning interrupt, the block also emits a recompute strobe for the downstream priority logic.

The peripheral lines are assumed synchronous to `clk`. The block records each line's level every cycle. A line set to edge mode latches pending on a 0-to-1 change. A line in level mode never latches pending; its level is simply exported.

A software request carries a target ID, a requested group and a non-secure flag. It is accepted only if two conditions hold:
- after a reconciliation step, its group agrees with the target's configured group;
- a non-secure request, when security is active, also passes a per-interrupt permission threshold.

All outputs are registered, so they appear one cycle after the event.

Top module: `pirq_front`

## Requirements
- R1: While `rst_n` is low, `level_o`, `pend_set_o` and `recompute_o` are all zero.
- R2: `level_o[k]` equals the value `line_i[k]` had at the previous rising clock edge.
- R3: When `line_i[k]` is 1 and the recorded `level_o[k]` is 0, and `edge_cfg_i[k]` is 1, then `pend_set_o[16+k]` is 1 for exactly one cycle, one cycle later. Holding the line high sets nothing further.
- R4: A line with `edge_cfg_i[k]` at 0 never drives `pend_set_o[16+k]`. A 1-to-0 change never sets pending, whatever the mode.
- R5: `recompute_o` is 1 in the cycle after any line level change (either direction, either mode) or any accepted software request. Otherwise it is 0.
- R6: Group codes are 2 bits: 00 is group 0, 01 is non-secure group 1, 10 is secure group 1. A target's configured code is {`grp_mod_i[n]`, `grp_bit_i[n]`}, but the modifier counts as 0 when `sec_off_i` is 1. A request whose `sgi_grp_i` is 11 is dropped.
- R7: A request for secure group 1 (10) whose target is configured as group 0 is handled as a group 0 request.
- R8: After the R7 adjustment, a request whose group code differs from the target's configured code is dropped.
- R9: When `sgi_ns_i` is 1 and `sec_off_i` is 0, the check uses `access_i[2n+1:2n]`. A group 0 target needs a value of at least 1. Any other target needs a value of at least 2. Otherwise the request is dropped. Secure requests, and all requests while `sec_off_i` is 1, skip this check.
- R10: An accepted request for ID n drives `pend_set_o[n]` high for one cycle, one cycle after `sgi_valid_i`. No other bit of `pend_set_o[15:0]` is set.
- R11: A line event and a software request in the same cycle both produce their pending-set bits in the same output cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | NUM_PPI | Peripheral lines for IDs 16 upward |
| edge_cfg_i | input | NUM_PPI | 1 = line k is edge mode |
| sgi_valid_i | input | 1 | Software request present this cycle |
| sgi_id_i | input | ID_W | Target ID of the request |
| sgi_grp_i | input | 2 | Requested group code |
| sgi_ns_i | input | 1 | Request comes from the non-secure side |
| sec_off_i | input | 1 | 1 = security disabled |
| grp_bit_i | input | NUM_SGI | Group bit per software interrupt |
| grp_mod_i | input | NUM_SGI | Group-modifier bit per software interrupt |
| access_i | input | 2*NUM_SGI | 2-bit non-secure permission per software interrupt |
| pend_set_o | output | NUM_SGI+NUM_PPI | One-cycle pending-set pulses, bit = interrupt ID |
| recompute_o | output | 1 | Recompute strobe for the priority logic |
| level_o | output | NUM_PPI | Recorded line levels |

## Verification
A stale or corrupted recorded level shows at `level_o` one cycle after the bad update. It also shows up as a missing or repeated edge pulse, or a spurious recompute, on the next line change. Faults in the software acceptance path show as a missing pulse, an extra pulse, or a pulse on the wrong bit, one cycle after the request. The bench therefore sweeps every combination of target ID, configured group, requested group, non-secure flag, security mode and permission value. It sets the other IDs' fields to the opposite values, so that reading from the wrong field position shows up. Each line is driven through rise, hold and fall in both modes, while the other lines are held in the opposite mode.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    typedef enum logic [1:0] {
        GRP_G0  = 2'b00,
        GRP_NS1 = 2'b01,
        GRP_S1  = 2'b10,
        GRP_RSV = 2'b11
    } pirq_grp_e;

    // Minimum non-secure permission value per target kind
    localparam logic [1:0] PERM_MIN_G0 = 2'd1;
    localparam logic [1:0] PERM_MIN_G1 = 2'd2;

endpackage

// File: rtl/pirq_line_edge.sv
module pirq_line_edge #(
    parameter int NUM_LINE = 16
) (
    input  logic [NUM_LINE-1:0] line_i,
    input  logic [NUM_LINE-1:0] level_q_i,
    input  logic [NUM_LINE-1:0] edge_cfg_i,
    output logic [NUM_LINE-1:0] level_d_o,
    output logic [NUM_LINE-1:0] set_o,
    output logic                changed_o
);

    logic [NUM_LINE-1:0] diff;

    for (genvar k = 0; k < NUM_LINE; k++) begin : g_line
        always_comb begin
            diff[k]      = line_i[k] ^ level_q_i[k];
            set_o[k]     = diff[k] & line_i[k] & edge_cfg_i[k];
            level_d_o[k] = diff[k] ? line_i[k] : level_q_i[k];
        end
    end

    assign changed_o = |diff;

endmodule

// File: rtl/pirq_sgi_gate.sv
module pirq_sgi_gate
    import pirq_pkg::*;
#(
    parameter int NUM_SGI = 16,
    localparam int ID_W   = $clog2(NUM_SGI)
) (
    input  logic                 valid_i,
    input  logic [ID_W-1:0]      id_i,
    input  logic [1:0]           grp_i,
    input  logic                 ns_i,
    input  logic                 sec_off_i,
    input  logic [NUM_SGI-1:0]   grp_bit_i,
    input  logic [NUM_SGI-1:0]   grp_mod_i,
    input  logic [2*NUM_SGI-1:0] access_i,
    output logic                 accept_o,
    output logic [NUM_SGI-1:0]   set_o
);

    pirq_grp_e   cfg_grp;
    pirq_grp_e   req_grp;
    logic [1:0]  perm;
    logic [1:0]  perm_min;
    logic        grp_ok;
    logic        perm_ok;

    always_comb begin
        cfg_grp  = pirq_grp_e'({grp_mod_i[id_i] & ~sec_off_i, grp_bit_i[id_i]});
        req_grp  = pirq_grp_e'(grp_i);
        // Secure group 1 aimed at a group 0 target is downgraded
        if (req_grp == GRP_S1 && cfg_grp == GRP_G0) begin
            req_grp = GRP_G0;
        end
        grp_ok   = (pirq_grp_e'(grp_i) != GRP_RSV) && (req_grp == cfg_grp);
        perm     = access_i[{id_i, 1'b0} +: 2];
        perm_min = (cfg_grp == GRP_G0) ? PERM_MIN_G0 : PERM_MIN_G1;
        perm_ok  = !(ns_i && !sec_off_i) || (perm >= perm_min);
        accept_o = valid_i && grp_ok && perm_ok;
        set_o    = accept_o ? (NUM_SGI'(1) << id_i) : '0;
    end

endmodule

// File: rtl/pirq_front.sv
module pirq_front #(
    parameter int  NUM_SGI  = 16,
    parameter int  NUM_PPI  = 16,
    localparam int ID_W     = $clog2(NUM_SGI),
    localparam int NUM_PRIV = NUM_SGI + NUM_PPI
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PPI-1:0]   line_i,
    input  logic [NUM_PPI-1:0]   edge_cfg_i,
    input  logic                 sgi_valid_i,
    input  logic [ID_W-1:0]      sgi_id_i,
    input  logic [1:0]           sgi_grp_i,
    input  logic                 sgi_ns_i,
    input  logic                 sec_off_i,
    input  logic [NUM_SGI-1:0]   grp_bit_i,
    input  logic [NUM_SGI-1:0]   grp_mod_i,
    input  logic [2*NUM_SGI-1:0] access_i,
    output logic [NUM_PRIV-1:0]  pend_set_o,
    output logic                 recompute_o,
    output logic [NUM_PPI-1:0]   level_o
);

    typedef struct packed {
        logic [NUM_PPI-1:0]  level;
        logic [NUM_PRIV-1:0] pend_set;
        logic                recompute;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_PPI-1:0] lvl_next;
    logic [NUM_PPI-1:0] line_set;
    logic               line_chg;
    logic               sgi_acc;
    logic [NUM_SGI-1:0] sgi_set;

    pirq_line_edge #(.NUM_LINE(NUM_PPI)) i_line (
        .line_i     (line_i),
        .level_q_i  (s_q.level),
        .edge_cfg_i (edge_cfg_i),
        .level_d_o  (lvl_next),
        .set_o      (line_set),
        .changed_o  (line_chg)
    );

    pirq_sgi_gate #(.NUM_SGI(NUM_SGI)) i_sgi (
        .valid_i   (sgi_valid_i),
        .id_i      (sgi_id_i),
        .grp_i     (sgi_grp_i),
        .ns_i      (sgi_ns_i),
        .sec_off_i (sec_off_i),
        .grp_bit_i (grp_bit_i),
        .grp_mod_i (grp_mod_i),
        .access_i  (access_i),
        .accept_o  (sgi_acc),
        .set_o     (sgi_set)
    );

    always_comb begin
        s_d           = s_q;
        s_d.level     = lvl_next;
        s_d.pend_set  = {line_set, sgi_set};
        s_d.recompute = line_chg | sgi_acc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_set_o  = s_q.pend_set;
    assign recompute_o = s_q.recompute;
    assign level_o     = s_q.level;

endmodule

// File: rtl/pirq_front_chk.sv
module pirq_front_chk #(
    parameter int  NUM_SGI  = 16,
    parameter int  NUM_PPI  = 16,
    localparam int ID_W     = $clog2(NUM_SGI),
    localparam int NUM_PRIV = NUM_SGI + NUM_PPI
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PPI-1:0]   line_i,
    input logic [NUM_PPI-1:0]   edge_cfg_i,
    input logic                 sgi_valid_i,
    input logic [ID_W-1:0]      sgi_id_i,
    input logic [1:0]           sgi_grp_i,
    input logic                 sgi_ns_i,
    input logic                 sec_off_i,
    input logic [2*NUM_SGI-1:0] access_i,
    input logic [NUM_PRIV-1:0]  pend_set_o,
    input logic                 recompute_o,
    input logic [NUM_PPI-1:0]   level_o
);

    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (level_o == $past(line_i)));  // R2

    AST_LEVEL_CHANGE_RECOMP: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o != $past(level_o)) |-> recompute_o);  // R5

    AST_PEND_RECOMP: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_set_o) |-> recompute_o);  // R5

    AST_SGI_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_set_o[NUM_SGI-1:0]));  // R10

    for (genvar k = 0; k < NUM_PPI; k++) begin : g_line_chk
        AST_EDGE_ONLY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            pend_set_o[NUM_SGI+k] |->
                $past(edge_cfg_i[k] && line_i[k] && !level_o[k]));  // R3
    end

    for (genvar n = 0; n < NUM_SGI; n++) begin : g_sgi_chk
        AST_SGI_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            pend_set_o[n] |->
                $past(sgi_valid_i && (sgi_id_i == ID_W'(n))));  // R10
        AST_SGI_NO_RSV: assert property (@(posedge clk) disable iff (!rst_n)
            pend_set_o[n] |-> ($past(sgi_grp_i) != 2'b11));  // R6
        AST_SGI_NS_PERM: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_set_o[n] && $past(sgi_ns_i && !sec_off_i)) |->
                ($past(access_i[2*n +: 2]) != 2'b00));  // R9
    end

endmodule

bind pirq_front pirq_front_chk #(.NUM_SGI(NUM_SGI), .NUM_PPI(NUM_PPI)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_i      (line_i),
    .edge_cfg_i  (edge_cfg_i),
    .sgi_valid_i (sgi_valid_i),
    .sgi_id_i    (sgi_id_i),
    .sgi_grp_i   (sgi_grp_i),
    .sgi_ns_i    (sgi_ns_i),
    .sec_off_i   (sec_off_i),
    .access_i    (access_i),
    .pend_set_o  (pend_set_o),
    .recompute_o (recompute_o),
    .level_o     (level_o)
);

// File: tb/test_pirq_front.sv
module test_pirq_front;

    localparam int NS = 16;
    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] line_i;
    logic [NP-1:0] edge_cfg_i;
    logic          sgi_valid_i;
    logic [3:0]    sgi_id_i;
    logic [1:0]    sgi_grp_i;
    logic          sgi_ns_i;
    logic          sec_off_i;
    logic [NS-1:0] grp_bit_i;
    logic [NS-1:0] grp_mod_i;
    logic [2*NS-1:0] access_i;
    logic [NS+NP-1:0] pend_set_o;
    logic          recompute_o;
    logic [NP-1:0] level_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pirq_front #(.NUM_SGI(NS), .NUM_PPI(NP)) i_pirq_front (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .edge_cfg_i(edge_cfg_i),
        .sgi_valid_i(sgi_valid_i), .sgi_id_i(sgi_id_i), .sgi_grp_i(sgi_grp_i),
        .sgi_ns_i(sgi_ns_i), .sec_off_i(sec_off_i), .grp_bit_i(grp_bit_i),
        .grp_mod_i(grp_mod_i), .access_i(access_i), .pend_set_o(pend_set_o),
        .recompute_o(recompute_o), .level_o(level_o)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Acceptance computed from the group and permission rules
    function automatic bit want(int cm, int cg, int rq, int ns, int soff, int acc);
        int g;
        int r;
        g = soff ? cg : (cm * 2 + cg);
        if (rq == 3) return 1'b0;                  // R6
        r = (rq == 2 && g == 0) ? 0 : rq;          // R7
        if (r != g) return 1'b0;                   // R8
        if (ns && !soff) return (g == 0) ? (acc >= 1) : (acc >= 2);  // R9
        return 1'b1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; line_i = '1; edge_cfg_i = '1; sgi_valid_i = 1'b1;
        sgi_id_i = 4'd3; sgi_grp_i = 2'b00; sgi_ns_i = 1'b0; sec_off_i = 1'b0;
        grp_bit_i = '0; grp_mod_i = '0; access_i = '1;
        repeat (3) @(negedge clk);
        chk(level_o == '0, "R1 level", level_o, 0);
        chk(pend_set_o == '0, "R1 pend", pend_set_o, 0);
        chk(recompute_o == 1'b0, "R1 recomp", recompute_o, 0);
        line_i = '0; sgi_valid_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Line sweep: rise, hold, fall, each line in each mode
        for (int k = 0; k < NP; k++) begin
            for (int e = 0; e < 2; e++) begin
                logic [NP-1:0] one;
                logic [NS+NP-1:0] exp_set;
                one = NP'(1) << k;
                edge_cfg_i = e ? one : ~one;
                exp_set = e ? ((NS+NP)'(1) << (NS + k)) : '0;
                line_i = one;
                @(negedge clk);
                chk(pend_set_o == exp_set, e ? "R3 rise" : "R4 level rise", pend_set_o, exp_set);
                chk(recompute_o == 1'b1, "R5 rise", recompute_o, 1);
                chk(level_o == one, "R2 level high", level_o, one);
                @(negedge clk);
                chk(pend_set_o == '0, "R3 hold", pend_set_o, 0);
                chk(recompute_o == 1'b0, "R5 hold", recompute_o, 0);
                line_i = '0;
                @(negedge clk);
                chk(pend_set_o == '0, "R4 fall", pend_set_o, 0);
                chk(recompute_o == 1'b1, "R5 fall", recompute_o, 1);
                chk(level_o == '0, "R2 level low", level_o, 0);
                @(negedge clk);
            end
        end

        // Exhaustive software request sweep
        for (int id = 0; id < NS; id++)
        for (int cm = 0; cm < 2; cm++)
        for (int cg = 0; cg < 2; cg++)
        for (int rq = 0; rq < 4; rq++)
        for (int ns = 0; ns < 2; ns++)
        for (int so = 0; so < 2; so++)
        for (int acc = 0; acc < 4; acc++) begin
            bit w;
            logic [NS+NP-1:0] exp_set;
            grp_bit_i = cg ? '0 : '1;
            grp_bit_i[id] = cg[0];
            grp_mod_i = cm ? '0 : '1;
            grp_mod_i[id] = cm[0];
            access_i = {NS{~acc[1:0]}};
            access_i[2*id +: 2] = acc[1:0];
            sgi_id_i = id[3:0]; sgi_grp_i = rq[1:0];
            sgi_ns_i = ns[0]; sec_off_i = so[0]; sgi_valid_i = 1'b1;
            w = want(cm, cg, rq, ns, so, acc);
            exp_set = w ? ((NS+NP)'(1) << id) : '0;
            @(negedge clk);
            sgi_valid_i = 1'b0;
            chk(pend_set_o == exp_set, "R10 R8 R9 sgi set", pend_set_o, exp_set);
            chk(recompute_o == w, "R5 sgi recomp", recompute_o, w);
            @(negedge clk);
        end

        // R7 spot check: secure group 1 request to group 0 target, non-secure allowed
        grp_bit_i = '0; grp_mod_i = '0; access_i = '0; access_i[2*9 +: 2] = 2'd1;
        sgi_id_i = 4'd9; sgi_grp_i = 2'b10; sgi_ns_i = 1'b1; sec_off_i = 1'b0;
        sgi_valid_i = 1'b1;
        @(negedge clk);
        sgi_valid_i = 1'b0;
        chk(pend_set_o == 32'h0000_0200, "R7 downgrade", pend_set_o, 32'h200);

        // R11: line rise and accepted request in the same cycle
        edge_cfg_i = '1; line_i = 16'h0008;
        sgi_id_i = 4'd5; sgi_grp_i = 2'b00; sgi_ns_i = 1'b0; sgi_valid_i = 1'b1;
        @(negedge clk);
        sgi_valid_i = 1'b0;
        chk(pend_set_o == 32'h0008_0020, "R11 both", pend_set_o, 32'h0008_0020);
        chk(recompute_o == 1'b1, "R11 recomp", recompute_o, 1);
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule